// File: doc/BRIEF.md
# Fixed-Point Second-Order Recursive Filter

This block is a streaming second-order recursive (IIR) filter for signed integer samples. Each sample offered with its valid strobe yields exactly one filtered sample one clock later. Along the way the block updates two stored past inputs and two stored past outputs. The filter gains are fixed integers, -14, 13 and -231, and each is read as a multiple of 2^-8. Together they approximate the fractions -0.0533, +0.0506 and -0.9025.

The three weighted history products are added in a wide accumulator before any scaling. The sum is then shifted right arithmetically by 8. The current input and the input from two samples back are added at unity weight after the shift. The result is clamped to the sample range. The clamped value is both the output and the value fed back into the output history.

The filter can sit in any sample stream that tolerates a one-cycle latency. Samples may arrive on consecutive cycles or with gaps of any length.

Top module: `iir2_filter`

## Requirements
- R1: While reset is applied, and afterwards until the first accepted sample, out_valid is 0 and out_data is 0. All four history values are zero, so the first sample after reset comes out unchanged, provided it is in range.
- R2: For an accepted sample x, the result is x + x2 + ((-14*x1 + 13*y1 - 231*y2) >>> 8). Here x1 and x2 are the two previous accepted inputs and y1 and y2 are the two previous outputs.
- R3: The shift by 8 is arithmetic and rounds toward minus infinity. For example, a weighted sum of -1 contributes -1 and a sum of -256 contributes -1.
- R4: The three weighted products are summed at full width before the shift. The products are never shifted one at a time.
- R5: A cycle with in_valid low leaves all four history values unchanged, and the next accepted sample continues the recursion as if no gap had occurred.
- R6: out_valid is 1 in the cycle after each cycle in which in_valid is 1, and 0 otherwise.
- R7: A result above 32767 is output as 32767 and a result below -32768 is output as -32768. The clamped value is the one stored as y1.
- R8: out_data keeps its last value while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | The sample on in_data is accepted this cycle |
| in_data | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | out_data carries a new filtered sample |
| out_data | output | SAMPLE_W | Signed, saturated filtered sample |

## Verification
The bench builds the block with its default parameters: SAMPLE_W = 16 and ACC_GUARD = 10, which gives a 26-bit accumulator. These values let full-scale input runs at both rails drive the weighted sum near its largest magnitude and push the result past both clamp limits. A scoreboard model with its own integer arithmetic predicts each output. Small negative streams exercise the floor rounding of the shift. Bursty, gapped pseudo-random streams show that idle cycles leave the recursion intact.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
  // Scale of the fixed gains: each gain is an integer times 2^-FRAC_SHIFT
  localparam int unsigned FRAC_SHIFT = 8;
  // Gains on the previous input, previous output and output two samples back
  localparam int GAIN_X1 = -14;
  localparam int GAIN_Y1 = 13;
  localparam int GAIN_Y2 = -231;
  // Number of past values kept per history line
  localparam int unsigned HIST_DEPTH = 2;
endpackage

// File: rtl/iir2_hist.sv
module iir2_hist #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [W-1:0]              d,
  output logic [DEPTH-1:0][W-1:0]   taps
);

  logic [DEPTH-1:0][W-1:0] taps_d;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb taps_d[s] = shift_en ? d : taps[s];
    end else begin : g_body
      always_comb taps_d[s] = shift_en ? taps[s-1] : taps[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= taps_d;
  end

endmodule

// File: rtl/iir2_mac.sv
module iir2_mac
  import iir2_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 26
) (
  input  logic signed [SAMPLE_W-1:0] x1,
  input  logic signed [SAMPLE_W-1:0] y1,
  input  logic signed [SAMPLE_W-1:0] y2,
  output logic signed [ACC_W-1:0]    acc_shr
);

  localparam logic signed [ACC_W-1:0] K_X1 = ACC_W'(GAIN_X1);
  localparam logic signed [ACC_W-1:0] K_Y1 = ACC_W'(GAIN_Y1);
  localparam logic signed [ACC_W-1:0] K_Y2 = ACC_W'(GAIN_Y2);

  logic signed [ACC_W-1:0] p_x1, p_y1, p_y2, acc;

  always_comb begin
    p_x1    = ACC_W'(x1) * K_X1;
    p_y1    = ACC_W'(y1) * K_Y1;
    p_y2    = ACC_W'(y2) * K_Y2;
    // full-width sum first, single scaling step afterwards
    acc     = p_x1 + p_y1 + p_y2;
    acc_shr = acc >>> FRAC_SHIFT;
  end

endmodule

// File: rtl/iir2_sat.sv
module iir2_sat #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  v,
  output logic signed [OUT_W-1:0] q
);

  localparam int EXT = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] HI = {{EXT{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = {{EXT{1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (v > HI)      q = HI[OUT_W-1:0];
    else if (v < LO) q = LO[OUT_W-1:0];
    else             q = v[OUT_W-1:0];
  end

endmodule

// File: rtl/iir2_filter.sv
module iir2_filter
  import iir2_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int ACC_GUARD = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_data,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_data
);

  localparam int ACC_W = SAMPLE_W + ACC_GUARD;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // history lines
  logic [HIST_DEPTH-1:0][SAMPLE_W-1:0] x_taps, y_taps;
  logic signed [SAMPLE_W-1:0]          y_sat;

  iir2_hist #(.W(SAMPLE_W), .DEPTH(HIST_DEPTH)) u_xhist (
    .clk      (clk),
    .rst_n    (rst_q),
    .shift_en (in_valid),
    .d        (in_data),
    .taps     (x_taps)
  );

  iir2_hist #(.W(SAMPLE_W), .DEPTH(HIST_DEPTH)) u_yhist (
    .clk      (clk),
    .rst_n    (rst_q),
    .shift_en (in_valid),
    .d        (y_sat),
    .taps     (y_taps)
  );

  // weighted history sum
  logic signed [ACC_W-1:0] acc_shr, sum_full;

  iir2_mac #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_mac (
    .x1      ($signed(x_taps[0])),
    .y1      ($signed(y_taps[0])),
    .y2      ($signed(y_taps[1])),
    .acc_shr (acc_shr)
  );

  // unity-weight terms join after the scaling
  always_comb
    sum_full = ACC_W'(in_data) + ACC_W'($signed(x_taps[1])) + acc_shr;

  iir2_sat #(.IN_W(ACC_W), .OUT_W(SAMPLE_W)) u_sat (
    .v (sum_full),
    .q (y_sat)
  );

  // output register
  logic                       out_valid_d;
  logic signed [SAMPLE_W-1:0] out_data_d;

  always_comb begin
    out_valid_d = in_valid;
    out_data_d  = in_valid ? y_sat : out_data;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_data  <= out_data_d;
    end
  end

endmodule

// File: rtl/iir2_filter_chk.sv
module iir2_filter_chk #(
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 26
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_data,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_data,
  input logic [SAMPLE_W-1:0]        x1,
  input logic signed [SUM_W-1:0]    sum
);

  localparam int EXT = SUM_W - SAMPLE_W + 1;
  localparam logic signed [SUM_W-1:0] HI = {{EXT{1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO = {{EXT{1'b1}}, {(SAMPLE_W-1){1'b0}}};

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r5_x_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (x1 == $past(in_data)));

  a_r5_x_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(x1));

  a_r7_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sum > HI)) |=> (out_data == HI[SAMPLE_W-1:0]));

  a_r7_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sum < LO)) |=> (out_data == LO[SAMPLE_W-1:0]));

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sum <= HI) && (sum >= LO)) |=> (out_data == $past(sum[SAMPLE_W-1:0])));

endmodule

bind iir2_filter iir2_filter_chk #(.SAMPLE_W(SAMPLE_W), .SUM_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .x1        (x_taps[0]),
  .sum       (sum_full)
);

// File: tb/iir2_filter_test.sv
`timescale 1ns/1ps
module iir2_filter_test;

  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic                out_valid;
  logic signed [W-1:0] out_data;

  iir2_filter #(.SAMPLE_W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #2.5 clk = ~clk;

  int      n_checks = 0;
  int      n_fail   = 0;
  bit      done     = 1'b0;
  bit      mon_en   = 1'b0;
  bit      exp_valid = 1'b0;
  longint  mx1, mx2, my1, my2;
  longint  last_push = 0;
  longint  q_val[$];
  string   q_tag[$];
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // golden model taken from the requirements
  function automatic longint model_step(input longint x);
    longint acc, y;
    acc = -14 * mx1 + 13 * my1 - 231 * my2;  // R4: whole sum before scaling
    y   = x + mx2 + (acc >>> 8);             // R3: floor shift
    if (y > 32767)  y = 32767;               // R7
    if (y < -32768) y = -32768;
    mx2 = mx1; mx1 = x;
    my2 = my1; my1 = y;
    return y;
  endfunction

  task automatic send(input longint x, input string tag);
    longint e;
    @(negedge clk); #1;
    in_valid  = 1'b1;
    in_data   = W'(x);
    e         = model_step(x);
    q_val.push_back(e);
    q_tag.push_back(tag);
    last_push = e;
    exp_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mon_en)
        check(longint'(out_data) == last_push, "R8 hold while idle", longint'(out_data), last_push);
      #1;
      in_valid  = 1'b0;
      exp_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    idle(3);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    last_push = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low in reset", longint'(out_valid), 0);
    check(out_data == '0, "R1 data zero in reset", longint'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low after reset", longint'(out_valid), 0);
    check(out_data == '0, "R1 data zero after reset", longint'(out_data), 0);
    mon_en = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_valid || out_valid)
        check(out_valid == exp_valid, "R6 valid timing", longint'(out_valid), longint'(exp_valid));
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R6 output with nothing pending", longint'(out_data), 0);
        end else begin
          longint e;
          string  t;
          e = q_val.pop_front();
          t = q_tag.pop_front();
          check(longint'(out_data) == e, t, longint'(out_data), e);
        end
      end
    end
  end

  function automatic longint rnd(input int amp);
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'($signed(seed[30:15])) % amp;
  endfunction

  initial begin
    do_reset();

    // R1: history cleared, first sample passes unchanged
    send(1000, "R1 first sample after reset");
    // R2: impulse tail
    for (int i = 0; i < 8; i++) send(0, "R2 impulse response");
    idle(1);

    // R5: gaps between samples
    send(500, "R5 gapped stream");
    idle(5);
    send(-300, "R5 gapped stream");
    idle(3);
    send(200, "R5 gapped stream");
    send(0, "R5 gapped stream");
    idle(2);
    send(0, "R5 gapped stream");

    // R3: small negative values, floor rounding
    do_reset();
    send(-1, "R3 floor shift");
    send(-3, "R3 floor shift");
    send(-7, "R3 floor shift");
    send(-100, "R3 floor shift");
    send(5, "R3 floor shift");
    send(-2, "R3 floor shift");

    // R4: terms that cancel only when summed before scaling
    do_reset();
    send(10, "R4 sum before shift");
    send(-1, "R4 sum before shift");
    send(0, "R4 sum before shift");
    send(19, "R4 sum before shift");
    send(-18, "R4 sum before shift");
    send(0, "R4 sum before shift");

    // R7: full scale at both rails
    do_reset();
    for (int i = 0; i < 6; i++) send(32767, "R7 positive clamp");
    for (int i = 0; i < 6; i++) send(-32768, "R7 negative clamp");
    for (int i = 0; i < 6; i++) send(0, "R7 clamped feedback decay");

    // R2: pseudo-random bursty stream
    do_reset();
    for (int i = 0; i < 200; i++) begin
      send(rnd(12000), "R2 random stream");
      if (rnd(4) == 0) idle(1 + int'(rnd(3) < 0 ? -rnd(3) : rnd(3)));
    end

    // R7: random full-scale stream
    for (int i = 0; i < 200; i++) send(rnd(32768), "R7 random full scale");

    idle(3);
    check(q_val.size() == 0, "R6 all outputs delivered", q_val.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule